// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Sequencer

This block drives the control strobes of an asynchronous DRAM during start-up and at refresh time. After reset it holds every strobe inactive for a supply-settling interval. It then runs a fixed number of warm-up cycles, each containing one row-strobe pulse, and only after those does it raise `ready`. From then on an interval timer marks one refresh as owed every `REF_INT` clocks. `REF_INT` defaults to the retention time divided by the number of rows, converted to clocks and derated by a few percent. The block asks the access controller for the bus, waits for the grant, runs a refresh cycle, and releases the bus once nothing more is owed.

Each cycle has three phases: a setup phase of `SU_CYC` clocks, a row-strobe-low phase of `RAS_CYC` clocks, and a precharge phase of `RP_CYC` clocks. Two refresh styles are available, and `cbrMode` picks one at the start of each cycle. In column-first mode, CAS goes low during setup and stays low while RAS is low, and the DRAM's own counter chooses the row. In row-address mode, CAS stays high, and the block presents its own row counter on `rowAddr` during setup and while RAS is low. That counter then advances by one. Refreshes that cannot be served while the bus is taken are remembered up to `OWED_MAX`. They are later issued one after another.

Top module: `dram_refresh_seq`

## Requirements
- R1: From reset until `WAIT_CYC` clocks after reset release, `rasN`, `casN`, `weN` and `oeN` are high, `rowAddr` is zero, and `busReq` and `ready` are low.
- R2: A cycle starts only in a clock where `busReq` is high and `busGnt` is sampled high. `busReq` stays high from that clock through the end of precharge. RAS never goes low while `busReq` is low.
- R3: Exactly `INIT_CYC` RAS pulses occur before `ready` rises. `ready` rises in the clock after the last warm-up precharge and stays high until reset.
- R4: A column-first cycle (`cbrMode`=1) drives `casN` low for `SU_CYC` clocks with `rasN` high, then both low for `RAS_CYC` clocks, then both high for `RP_CYC` clocks. `rowAddr` stays 0 throughout.
- R5: A row-address cycle (`cbrMode`=0) keeps `casN` high. It drives `rowAddr` with the row counter, held constant, for the `SU_CYC` setup clocks and the `RAS_CYC` clocks with `rasN` low. Outside those clocks `rowAddr` is 0.
- R6: The row counter starts at 0 after reset. It advances by one, modulo 2^`ROW_W`, after each row-address cycle, including warm-up cycles. Column-first cycles leave it unchanged.
- R7: Once `ready` is high, one refresh becomes owed every `REF_INT` clocks. The owed count saturates at `OWED_MAX`, and each completed refresh cycle reduces it by one.
- R8: While refreshes are owed and the grant stays high, cycles follow one another with exactly one idle clock between them. `busReq` falls in the clock after the precharge in which the owed count reaches zero.
- R9: `weN` and `oeN` are high in every clock.
- R10: `cbrMode` is sampled only in the clock that starts a cycle. A change during a cycle has no effect on that cycle's strobes or address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cbrMode | input | 1 | 1 = column-first refresh, 0 = row-address refresh |
| busGnt | input | 1 | Access controller grants the DRAM bus |
| busReq | output | 1 | Sequencer requests or holds the DRAM bus |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, held high |
| oeN | output | 1 | Output enable, held high |
| rowAddr | output | ROW_W | Refresh row address in row-address mode, else 0 |
| ready | output | 1 | Warm-up complete; host traffic may begin |

## Verification
The bench withholds the grant for several refresh intervals so that the owed count must saturate. A design without saturation would then issue a burst longer than `OWED_MAX`, and one that drops owed refreshes would issue fewer. It toggles `cbrMode` while cycles are in progress. A design that reads the mode each clock would mix CAS-low and CAS-high phases within one pulse. A long run in row-address mode wraps the small row counter, which exposes a missed increment, a counter that moves on column-first cycles, or a wrong wrap. The warm-up pulses are counted against the rise of `ready`, so an off-by-one in the warm-up count shifts `ready` by a whole cycle.

// File: rtl/drs_pkg.sv
package drs_pkg;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_PRECH
  } seqState_t;

  typedef enum logic [1:0] {
    PH_SETUP  = 2'd0,
    PH_ACTIVE = 2'd1,
    PH_PRECH  = 2'd2
  } phaseSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic      waitEn;
    logic      phaseClr;
    phaseSel_t phaseSel;
    logic      latchMode;
    logic      rowInc;
    logic      cycDone;
  } seqCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic waitDone;
    logic phaseEnd;
    logic ready;
    logic owedNz;
    logic modeCbr;
  } seqSts_t;

endpackage

// File: rtl/drs_dp.sv
module drs_dp
  import drs_pkg::*;
#(
  parameter int ROW_W    = 11,
  parameter int WAIT_CYC = 50000,
  parameter int INIT_CYC = 8,
  parameter int REF_INT  = 3788,
  parameter int OWED_MAX = 8,
  parameter int SU_CYC   = 2,
  parameter int RAS_CYC  = 12,
  parameter int RP_CYC   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cbrMode,
  input  seqCtl_t          ctl,
  output seqSts_t          sts,
  output logic [ROW_W-1:0] rowCnt
);

  localparam int WAIT_W = $clog2(WAIT_CYC + 1);
  localparam int INIT_W = $clog2(INIT_CYC + 1);
  localparam int REF_W  = $clog2(REF_INT + 1);
  localparam int OWED_W = $clog2(OWED_MAX + 1);
  localparam int PH_MAX = (SU_CYC > RAS_CYC) ? ((SU_CYC > RP_CYC) ? SU_CYC : RP_CYC)
                                             : ((RAS_CYC > RP_CYC) ? RAS_CYC : RP_CYC);
  localparam int PH_W   = $clog2(PH_MAX + 1);

  logic [WAIT_W-1:0] waitCnt;
  logic [INIT_W-1:0] initCnt;
  logic [REF_W-1:0]  refTimer;
  logic [OWED_W-1:0] owed;
  logic [PH_W-1:0]   phaseCnt;
  logic [PH_W-1:0]   phaseLast;
  logic              readyQ;
  logic              modeQ;
  logic              tick;
  logic              owedDec;

  // last count of the current phase
  always_comb begin
    case (ctl.phaseSel)
      PH_SETUP:  phaseLast = PH_W'(SU_CYC - 1);
      PH_ACTIVE: phaseLast = PH_W'(RAS_CYC - 1);
      default:   phaseLast = PH_W'(RP_CYC - 1);
    endcase
  end

  assign tick    = readyQ && (refTimer == REF_W'(REF_INT - 1));
  assign owedDec = ctl.cycDone && readyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt  <= '0;
      phaseCnt <= '0;
    end else begin
      if (ctl.waitEn && (waitCnt != WAIT_W'(WAIT_CYC - 1))) waitCnt <= waitCnt + 1'b1;
      if (ctl.phaseClr) phaseCnt <= '0;
      else              phaseCnt <= phaseCnt + 1'b1;
    end
  end

  // warm-up counting and ready flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initCnt <= '0;
      readyQ  <= 1'b0;
    end else if (ctl.cycDone && !readyQ) begin
      initCnt <= initCnt + 1'b1;
      if (initCnt == INIT_W'(INIT_CYC - 1)) readyQ <= 1'b1;
    end
  end

  // refresh interval timer and owed count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refTimer <= '0;
      owed     <= '0;
    end else begin
      if (readyQ) refTimer <= tick ? '0 : refTimer + 1'b1;
      if (tick && !owedDec && (owed != OWED_W'(OWED_MAX))) owed <= owed + 1'b1;
      else if (owedDec && !tick)                           owed <= owed - 1'b1;
    end
  end

  // mode capture and own row counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= 1'b1;
      rowCnt <= '0;
    end else begin
      if (ctl.latchMode) modeQ <= cbrMode;
      if (ctl.rowInc)    rowCnt <= rowCnt + 1'b1;
    end
  end

  assign sts.waitDone = ctl.waitEn && (waitCnt == WAIT_W'(WAIT_CYC - 1));
  assign sts.phaseEnd = (phaseCnt == phaseLast);
  assign sts.ready    = readyQ;
  assign sts.owedNz   = (owed != '0);
  assign sts.modeCbr  = modeQ;

endmodule

// File: rtl/drs_ctrl.sv
module drs_ctrl
  import drs_pkg::*;
#(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busGnt,
  input  seqSts_t          sts,
  input  logic [ROW_W-1:0] rowCnt,
  output seqCtl_t          ctl,
  output logic             busReq,
  output logic             rasN,
  output logic             casN,
  output logic             weN,
  output logic             oeN,
  output logic [ROW_W-1:0] rowAddr
);

  seqState_t state, stateNext;
  logic      pending;
  logic      inPulse;

  assign pending = !sts.ready || sts.owedNz;
  assign inPulse = (state == ST_SETUP) || (state == ST_ACTIVE);

  always_comb begin
    stateNext    = state;
    ctl          = '0;
    ctl.waitEn   = (state == ST_WAIT);
    case (state)
      ST_ACTIVE: ctl.phaseSel = PH_ACTIVE;
      ST_PRECH:  ctl.phaseSel = PH_PRECH;
      default:   ctl.phaseSel = PH_SETUP;
    endcase
    case (state)
      ST_WAIT: if (sts.waitDone) stateNext = ST_IDLE;
      ST_IDLE: begin
        ctl.phaseClr = 1'b1;
        if (pending && busGnt) begin
          stateNext     = ST_SETUP;
          ctl.latchMode = 1'b1;
        end
      end
      ST_SETUP: if (sts.phaseEnd) begin
        stateNext    = ST_ACTIVE;
        ctl.phaseClr = 1'b1;
      end
      ST_ACTIVE: if (sts.phaseEnd) begin
        stateNext    = ST_PRECH;
        ctl.phaseClr = 1'b1;
        ctl.rowInc   = !sts.modeCbr;
      end
      ST_PRECH: if (sts.phaseEnd) begin
        stateNext    = ST_IDLE;
        ctl.phaseClr = 1'b1;
        ctl.cycDone  = 1'b1;
      end
      default: stateNext = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_WAIT;
    else       state <= stateNext;
  end

  assign busReq  = (state == ST_SETUP) || (state == ST_ACTIVE) || (state == ST_PRECH) ||
                   ((state == ST_IDLE) && pending);
  assign rasN    = (state != ST_ACTIVE);
  assign casN    = !(sts.modeCbr && inPulse);
  assign weN     = 1'b1;
  assign oeN     = 1'b1;
  assign rowAddr = (!sts.modeCbr && inPulse) ? rowCnt : '0;

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import drs_pkg::*;
#(
  parameter int CLK_MHZ    = 250,
  parameter int PWRUP_US   = 200,
  parameter int RETAIN_US  = 32000,
  parameter int DERATE_PCT = 97,
  parameter int ROW_W      = 11,
  parameter int WAIT_CYC   = PWRUP_US * CLK_MHZ,
  parameter int INIT_CYC   = 8,
  parameter int REF_INT    = RETAIN_US * CLK_MHZ / (2 ** ROW_W) * DERATE_PCT / 100,
  parameter int OWED_MAX   = 8,
  parameter int SU_CYC     = 2,
  parameter int RAS_CYC    = 12,
  parameter int RP_CYC     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cbrMode,
  input  logic             busGnt,
  output logic             busReq,
  output logic             rasN,
  output logic             casN,
  output logic             weN,
  output logic             oeN,
  output logic [ROW_W-1:0] rowAddr,
  output logic             ready
);

  seqCtl_t          ctl;
  seqSts_t          sts;
  logic [ROW_W-1:0] rowCnt;

  drs_ctrl #(.ROW_W(ROW_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busGnt(busGnt), .sts(sts), .rowCnt(rowCnt),
    .ctl(ctl), .busReq(busReq), .rasN(rasN), .casN(casN),
    .weN(weN), .oeN(oeN), .rowAddr(rowAddr)
  );

  drs_dp #(
    .ROW_W(ROW_W), .WAIT_CYC(WAIT_CYC), .INIT_CYC(INIT_CYC), .REF_INT(REF_INT),
    .OWED_MAX(OWED_MAX), .SU_CYC(SU_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cbrMode(cbrMode), .ctl(ctl), .sts(sts), .rowCnt(rowCnt)
  );

  assign ready = sts.ready;

endmodule

// File: rtl/drs_chk.sv
module drs_chk #(
  parameter int ROW_W = 11
) (
  input logic             clk,
  input logic             rstN,
  input logic             busGnt,
  input logic             busReq,
  input logic             rasN,
  input logic             casN,
  input logic             weN,
  input logic             oeN,
  input logic [ROW_W-1:0] rowAddr,
  input logic             ready
);

  AST_WE_OE_HIGH: assert property (@(posedge clk) disable iff (!rstN) weN && oeN); // R9
  AST_RAS_OWNS_BUS: assert property (@(posedge clk) disable iff (!rstN) !rasN |-> busReq); // R2
  AST_CAS_START_GRANTED: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casN) |-> $past(busGnt)); // R2
  AST_CBR_CAS_LEADS: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rasN) && !casN) |-> !$past(casN)); // R4
  AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!rasN && casN) |-> $stable(rowAddr)); // R5
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rstN) ready |=> ready); // R3

endmodule

bind dram_refresh_seq drs_chk #(.ROW_W(ROW_W)) u_drsChk (.*);

// File: tb/dram_refresh_seq_bench.sv
module dram_refresh_seq_bench;

  localparam int ROW_W    = 4;
  localparam int WAIT_CYC = 40;
  localparam int INIT_CYC = 8;
  localparam int REF_INT  = 60;
  localparam int OWED_MAX = 3;
  localparam int SU_CYC   = 2;
  localparam int RAS_CYC  = 3;
  localparam int RP_CYC   = 2;
  localparam int ROWS     = 1 << ROW_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cbrMode = 1'b1;
  logic busGnt = 1'b0;
  logic busReq, rasN, casN, weN, oeN, ready;
  logic [ROW_W-1:0] rowAddr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  dram_refresh_seq #(
    .ROW_W(ROW_W), .WAIT_CYC(WAIT_CYC), .INIT_CYC(INIT_CYC), .REF_INT(REF_INT),
    .OWED_MAX(OWED_MAX), .SU_CYC(SU_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)
  ) u_dram_refresh_seq (
    .clk(clk), .rstN(rstN), .cbrMode(cbrMode), .busGnt(busGnt), .busReq(busReq),
    .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN), .rowAddr(rowAddr), .ready(ready)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // behavioural reference: phase 0 wait, 1 idle, 2 setup, 3 ras low, 4 precharge
  int ms, mWait, mPh, mInit, mTimer, mOwed, mRow;
  bit mReady, mMode;

  always @(posedge clk) begin
    if (!rstN) begin
      ms = 0; mWait = 0; mPh = 0; mInit = 0; mTimer = 0; mOwed = 0; mRow = 0;
      mReady = 0; mMode = 1;
    end else begin
      bit tick, fin, newReady;
      tick = mReady && (mTimer == REF_INT - 1);
      fin = 0;
      newReady = mReady;
      if (mReady) mTimer = tick ? 0 : mTimer + 1;
      case (ms)
        0: begin mWait++; if (mWait == WAIT_CYC) ms = 1; end
        1: if ((!mReady || mOwed > 0) && busGnt) begin ms = 2; mPh = 0; mMode = cbrMode; end
        2: if (mPh == SU_CYC - 1) begin ms = 3; mPh = 0; end else mPh++;
        3: if (mPh == RAS_CYC - 1) begin
             ms = 4; mPh = 0;
             if (!mMode) mRow = (mRow + 1) % ROWS;
           end else mPh++;
        default: if (mPh == RP_CYC - 1) begin ms = 1; mPh = 0; fin = 1; end else mPh++;
      endcase
      if (fin && !mReady) begin
        mInit++;
        if (mInit == INIT_CYC) newReady = 1;
      end
      if (tick && !(fin && mReady) && mOwed < OWED_MAX) mOwed++;
      else if ((fin && mReady) && !tick) mOwed--;
      mReady = newReady;
    end
  end

  // per-clock comparison and directed monitors, sampled mid-period
  bit prevRas = 1'b1;
  bit prevReady = 1'b0;
  int initFalls = 0;
  int lastRow = -1;

  always @(negedge clk) begin
    int eRow;
    bit inPulse;
    string t;
    inPulse = (ms == 2) || (ms == 3);
    eRow = (!mMode && inPulse) ? mRow : 0;
    t = (ms == 0) ? "R1" : "";
    check({t, " R4/R10 rasN"}, int'(rasN), (ms == 3) ? 0 : 1);
    check({t, " R4/R5/R10 casN"}, int'(casN), (mMode && inPulse) ? 0 : 1);
    check({t, " R5/R6 rowAddr"}, int'(rowAddr), eRow);
    check({t, " R2/R8 busReq"}, int'(busReq),
          (ms >= 2 || (ms == 1 && (!mReady || mOwed > 0))) ? 1 : 0);
    check({t, " R3/R7 ready"}, int'(ready), int'(mReady));
    check("R9 weN/oeN", int'(weN && oeN), 1);
    if (rstN) begin
      if (prevRas && !rasN) begin
        if (!ready) initFalls++;
        if (casN) begin
          if (lastRow >= 0) check("R6 row step", int'(rowAddr), (lastRow + 1) % ROWS);
          lastRow = int'(rowAddr);
        end
      end
      if (!prevReady && ready) check("R3 warm-up pulse count", initFalls, INIT_CYC);
      prevRas = rasN;
      prevReady = ready;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      finishRun();
    end
  end

  initial begin
    int burst;
    repeat (5) @(negedge clk);
    check("R1 reset busReq", int'(busReq), 0);
    rstN = 1'b1;
    busGnt = 1'b1;
    // mixed modes, toggled mid-cycle too (R10)
    for (int i = 0; i < 700; i++) begin
      @(negedge clk);
      cbrMode = ((i / 3) % 5 == 1) ? 1'b0 : (((i / 11) % 2) == 0);
    end
    // withhold the bus so owed refreshes pile up and saturate (R7)
    busGnt = 1'b0;
    cbrMode = 1'b1;
    repeat (400) @(negedge clk);
    check("R7 owed pending request", int'(busReq), 1);
    busGnt = 1'b1;
    burst = 0;
    for (int i = 0; i < (OWED_MAX * (SU_CYC + RAS_CYC + RP_CYC + 1) + 2); i++) begin
      @(negedge clk);
      if (prevRas && !rasN) burst++;
    end
    checks++;
    if (burst < OWED_MAX || burst > OWED_MAX + 1) begin
      errors++;
      $display("FAIL R7/R8 burst: actual %0d expected %0d", burst, OWED_MAX);
    end
    // long row-address run wraps the row counter (R6)
    cbrMode = 1'b0;
    repeat (1600) @(negedge clk);
    // grant dropped and restored while in column-first mode
    cbrMode = 1'b1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      busGnt = ((i / 37) % 2) == 0;
    end
    busGnt = 1'b1;
    repeat (100) @(negedge clk);
    finishRun();
  end

endmodule